// File: doc/BRIEF.md
# Per-Peripheral Access Firewall

This block guards a set of peripheral slots (up to 128). For every slot it stores a secure flag, a privileged flag, a sticky lock, a compartment-ID (CID) filter word and a hardware semaphore. An access-check port takes a slot index with the requester's secure flag, privileged flag and CID, and answers with a grant in the same cycle. The answer comes from a fixed sequence of tests. Security is tested first, then privilege. The CID test comes last and has two forms: either one static owner CID, or a semaphore guarded by a whitelist of CIDs.

Software sets up the firewall through a 32-bit register port. Each write on that port carries the writer's CID, secure flag and privileged flag. A slot's settings can be frozen by its lock bit, and all slot settings can be frozen at once by a global lock. Only the trusted-domain CID may change a CID filter word. That CID lives in a separate master-control register, and this register has its own lock. A write that is refused leaves the state unchanged and raises a one-cycle error pulse. Semaphore words are still writable when a slot is locked, because they are runtime state.

Top module: `fw_filter`

## Requirements
- R1: After reset, all slot settings and locks are zero, no semaphore is held, and the trusted CID equals TD_CID_RST. Register 0x000 reads 0, register 0xC00 reads TD_CID_RST in bits 6:4, and any check on an implemented slot is granted.
- R2: The secure flags sit in a bank at 0x010 + 4*(idx/32), bit idx%32. A non-secure check (chk_sec_i=0) on a slot whose secure flag is set is denied.
- R3: The privileged flags sit in a bank at 0x030 + 4*(idx/32), bit idx%32. A check that passes the security test but has chk_priv_i=0 on a slot whose privileged flag is set is denied.
- R4: The CID filter word of slot idx is at 0x100 + 8*idx. Bit 0 enables filtering, bit 1 selects semaphore mode, bits 6:4 hold the static CID and bits 23:16 hold the whitelist (bit 16+c for CID c). All other bits read 0. When bit 0 is clear, a check that passes the security and privilege tests is granted.
- R5: In static mode (bit 0 = 1, bit 1 = 0), a check is granted only when chk_cid_i equals the static CID.
- R6: In semaphore mode (bits 1:0 = 11), a check is granted only when the requester's CID is whitelisted, the semaphore is taken, and the requester is the holder.
- R7: The semaphore word of slot idx is at 0x104 + 8*idx. It reads back as taken in bit 0 and holder CID in bits 6:4. A write with bit 0 = 1 takes the semaphore only when semaphore mode is selected, the semaphore is free and the writer's CID is whitelisted. A write with bit 0 = 0 releases it only when the writer is the holder. All other semaphore writes have no effect.
- R8: Lock flags are in a bank at 0x050 + 4*(idx/32). Writing 1 sets a flag, and the flag stays set until reset. For a locked slot, the secure flag, the privileged flag and the CID word do not change. A CID-word write to a locked slot raises an error. A secure or privileged bank write that would change a locked slot's bit also raises an error, while the unlocked bits in the same word are still updated.
- R9: Bit 0 of register 0x000 is a global lock that stays set until reset. While it is set, writes to 0x000, to the three banks and to CID words are ignored and raise an error. Semaphores keep working.
- R10: Register 0xC00 holds a master lock in bit 0 and the trusted CID in bits 6:4. A CID-word write from any other CID is ignored and raises an error. Once the master lock is set, writes to 0xC00 are ignored and raise an error.
- R11: Register 0xFEC reads NUM_PERIPH in bits 15:0 and NUM_MASTER in bits 23:16. Register 0xFF4 reads VER_MIN in bits 3:0 and VER_MAJ in bits 7:4. Writes to either register have no effect.
- R12: For a slot index at or above NUM_PERIPH, the register words read as zero, writes are ignored without error, bank bits read zero, and every check is denied.
- R13: reg_err_o is high for exactly the one cycle after an offending write. It stays low after a legal write.
- R14: A write to 0x000, to the banks, to a CID word or to 0xC00 from a writer that is not both secure and privileged is ignored and raises an error. Semaphore words take no account of the writer's secure and privileged flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | Write when high, read when low |
| reg_addr_i | input | 12 | Byte address |
| reg_wdata_i | input | 32 | Write data |
| reg_cid_i | input | 3 | Writer CID |
| reg_sec_i | input | 1 | Writer is secure |
| reg_priv_i | input | 1 | Writer is privileged |
| reg_rdata_o | output | 32 | Read data, combinational from address |
| reg_err_o | output | 1 | Refused-write pulse, one cycle late |
| chk_idx_i | input | 7 | Slot index to check |
| chk_sec_i | input | 1 | Access is secure |
| chk_priv_i | input | 1 | Access is privileged |
| chk_cid_i | input | 3 | Requester CID |
| chk_grant_o | output | 1 | Access allowed |

## Verification
The bench builds the block with NUM_PERIPH = 40, TD_CID_RST = 1, NUM_MASTER = 16 and version 2.1. With 40 slots, the second word of each bank is only partly implemented, so writes to the upper bits of that word can be seen being dropped, and indices from 40 to 127 can be checked as out of range. Because the trusted CID resets to 1, the bench can move it to 2 and freeze it with the master lock. It can then watch the same CID-word write be refused before the move and accepted after it.

// File: rtl/fw_filter_pkg.sv
package fw_filter_pkg;
  localparam int CID_W     = 3;
  localparam int NCID      = 1 << CID_W;
  localparam int MAX_SLOTS = 128;
  localparam int IDX_W     = $clog2(MAX_SLOTS);
  localparam int AW        = 12;
  localparam int DW        = 32;

  typedef struct packed {
    logic [NCID-1:0]  wl;
    logic [CID_W-1:0] scid;
    logic             sem_en;
    logic             cfen;
  } cid_cfg_t;
endpackage

// File: rtl/fw_slot.sv
module fw_slot
  import fw_filter_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             glock_i,
  input  logic             wr_sec_i,
  input  logic             wr_priv_i,
  input  logic             wr_lock_i,
  input  logic             bit_i,
  input  logic             wr_cfg_i,
  input  logic             trust_i,
  input  cid_cfg_t         cfg_w_i,
  input  logic             wr_sem_i,
  input  logic             sem_take_i,
  input  logic [CID_W-1:0] wcid_i,
  output logic             sec_o,
  output logic             priv_o,
  output logic             lock_o,
  output cid_cfg_t         cfg_o,
  output logic             taken_o,
  output logic [CID_W-1:0] holder_o
);
  logic             sec_q, priv_q, lock_q, taken_q;
  cid_cfg_t         cfg_q;
  logic [CID_W-1:0] holder_q;
  logic             frozen;

  assign frozen = lock_q | glock_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q    <= 1'b0;
      priv_q   <= 1'b0;
      lock_q   <= 1'b0;
      cfg_q    <= '0;
      taken_q  <= 1'b0;
      holder_q <= '0;
    end else begin
      if (wr_sec_i && !frozen) sec_q <= bit_i;
      if (wr_priv_i && !frozen) priv_q <= bit_i;
      if (wr_lock_i && !glock_i && bit_i) lock_q <= 1'b1;
      if (wr_cfg_i && !frozen && trust_i) cfg_q <= cfg_w_i;
      if (wr_sem_i) begin
        if (sem_take_i) begin
          if (!taken_q && cfg_q.sem_en && cfg_q.wl[wcid_i]) begin
            taken_q  <= 1'b1;
            holder_q <= wcid_i;
          end
        end else if (taken_q && holder_q == wcid_i) begin
          taken_q  <= 1'b0;
          holder_q <= '0;
        end
      end
    end
  end

  assign sec_o    = sec_q;
  assign priv_o   = priv_q;
  assign lock_o   = lock_q;
  assign cfg_o    = cfg_q;
  assign taken_o  = taken_q;
  assign holder_o = holder_q;

  p_lock_freeze_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> $stable(cfg_q) && $stable(sec_q) && $stable(priv_q));

  p_lock_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> lock_q);

  p_sem_take_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(taken_q) |-> cfg_q.sem_en && cfg_q.wl[holder_q]);

  p_sem_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(taken_q) |-> $past(wcid_i) == $past(holder_q));
endmodule

// File: rtl/fw_decide.sv
module fw_decide
  import fw_filter_pkg::*;
(
  input  logic             in_range_i,
  input  logic             slot_sec_i,
  input  logic             slot_priv_i,
  input  cid_cfg_t         cfg_i,
  input  logic             taken_i,
  input  logic [CID_W-1:0] holder_i,
  input  logic             req_sec_i,
  input  logic             req_priv_i,
  input  logic [CID_W-1:0] req_cid_i,
  output logic             grant_o
);
  // fixed order: range, security, privilege, then CID
  always_comb begin
    if (!in_range_i)                     grant_o = 1'b0;
    else if (!req_sec_i && slot_sec_i)   grant_o = 1'b0;
    else if (!req_priv_i && slot_priv_i) grant_o = 1'b0;
    else if (!cfg_i.cfen)                grant_o = 1'b1;
    else if (cfg_i.sem_en)
      grant_o = cfg_i.wl[req_cid_i] && taken_i && (holder_i == req_cid_i);
    else
      grant_o = (cfg_i.scid == req_cid_i);
  end
endmodule

// File: rtl/fw_filter.sv
module fw_filter
  import fw_filter_pkg::*;
#(
  parameter int NUM_PERIPH = 40,
  parameter int NUM_MASTER = 16,
  parameter int TD_CID_RST = 1,
  parameter int VER_MAJ    = 2,
  parameter int VER_MIN    = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_req_i,
  input  logic             reg_we_i,
  input  logic [AW-1:0]    reg_addr_i,
  input  logic [DW-1:0]    reg_wdata_i,
  input  logic [CID_W-1:0] reg_cid_i,
  input  logic             reg_sec_i,
  input  logic             reg_priv_i,
  output logic [DW-1:0]    reg_rdata_o,
  output logic             reg_err_o,
  input  logic [IDX_W-1:0] chk_idx_i,
  input  logic             chk_sec_i,
  input  logic             chk_priv_i,
  input  logic [CID_W-1:0] chk_cid_i,
  output logic             chk_grant_o
);
  localparam int NUM_WORDS = (NUM_PERIPH + 31) / 32;
  localparam int PADW      = NUM_WORDS * 32;

  logic             glock_q, mglock_q, err_q;
  logic [CID_W-1:0] tdcid_q;

  // decode
  logic             wr, attr_ok, wr_ok;
  logic             is_ctrl, is_sec, is_priv, is_lock, is_mctrl, is_cap, is_ver;
  logic             bank_ok, is_slot, slot_in, slot_sub, cfgspace;
  logic [1:0]       bank_k;
  logic [IDX_W-1:0] slot_idx;
  logic             trust;
  cid_cfg_t         cfg_w;

  assign wr      = reg_req_i & reg_we_i;
  assign attr_ok = reg_sec_i & reg_priv_i;
  assign wr_ok   = wr & attr_ok;
  assign trust   = (reg_cid_i == tdcid_q);

  assign bank_k   = reg_addr_i[3:2];
  assign bank_ok  = (int'(bank_k) < NUM_WORDS) && (reg_addr_i[1:0] == 2'b00);
  assign is_ctrl  = (reg_addr_i == 12'h000);
  assign is_sec   = (reg_addr_i[11:4] == 8'h01) && bank_ok;
  assign is_priv  = (reg_addr_i[11:4] == 8'h03) && bank_ok;
  assign is_lock  = (reg_addr_i[11:4] == 8'h05) && bank_ok;
  assign is_mctrl = (reg_addr_i == 12'hC00);
  assign is_cap   = (reg_addr_i == 12'hFEC);
  assign is_ver   = (reg_addr_i == 12'hFF4);

  assign is_slot  = (reg_addr_i >= 12'h100) && (reg_addr_i < 12'h500) &&
                    (reg_addr_i[1:0] == 2'b00);
  assign slot_idx = IDX_W'(reg_addr_i[10:3] - 8'h20);
  assign slot_sub = reg_addr_i[2];
  assign slot_in  = is_slot && (int'(slot_idx) < NUM_PERIPH);
  assign cfgspace = is_ctrl | is_sec | is_priv | is_lock | is_mctrl |
                    (slot_in & ~slot_sub);

  assign cfg_w = '{wl: reg_wdata_i[23:16], scid: reg_wdata_i[6:4],
                   sem_en: reg_wdata_i[1], cfen: reg_wdata_i[0]};

  // per-slot state
  logic             sec_v    [NUM_PERIPH];
  logic             priv_v   [NUM_PERIPH];
  logic             lock_v   [NUM_PERIPH];
  logic             taken_v  [NUM_PERIPH];
  cid_cfg_t         cfg_a    [NUM_PERIPH];
  logic [CID_W-1:0] holder_a [NUM_PERIPH];

  for (genvar s = 0; s < NUM_PERIPH; s++) begin : g_slot
    localparam int W = s / 32;
    localparam int B = s % 32;
    logic hit_w, hit_s;
    assign hit_w = (int'(bank_k) == W);
    assign hit_s = slot_in && (slot_idx == IDX_W'(s));

    fw_slot u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .glock_i    (glock_q),
      .wr_sec_i   (wr_ok && is_sec && hit_w),
      .wr_priv_i  (wr_ok && is_priv && hit_w),
      .wr_lock_i  (wr_ok && is_lock && hit_w),
      .bit_i      (reg_wdata_i[B]),
      .wr_cfg_i   (wr_ok && hit_s && !slot_sub),
      .trust_i    (trust),
      .cfg_w_i    (cfg_w),
      .wr_sem_i   (wr && hit_s && slot_sub),
      .sem_take_i (reg_wdata_i[0]),
      .wcid_i     (reg_cid_i),
      .sec_o      (sec_v[s]),
      .priv_o     (priv_v[s]),
      .lock_o     (lock_v[s]),
      .cfg_o      (cfg_a[s]),
      .taken_o    (taken_v[s]),
      .holder_o   (holder_a[s])
    );
  end

  // padded bank views and selections
  logic [PADW-1:0]  sec_pad, priv_pad, lock_pad;
  logic             sec_diff, priv_diff, rd_lock;
  cid_cfg_t         rd_cfg;
  logic             rd_taken;
  logic [CID_W-1:0] rd_holder;

  always_comb begin
    sec_pad   = '0;
    priv_pad  = '0;
    lock_pad  = '0;
    sec_diff  = 1'b0;
    priv_diff = 1'b0;
    rd_lock   = 1'b0;
    rd_cfg    = '0;
    rd_taken  = 1'b0;
    rd_holder = '0;
    for (int s = 0; s < NUM_PERIPH; s++) begin
      sec_pad[s]  = sec_v[s];
      priv_pad[s] = priv_v[s];
      lock_pad[s] = lock_v[s];
      if (int'(bank_k) == s / 32 && lock_v[s]) begin
        if (reg_wdata_i[s % 32] != sec_v[s])  sec_diff  = 1'b1;
        if (reg_wdata_i[s % 32] != priv_v[s]) priv_diff = 1'b1;
      end
      if (slot_idx == IDX_W'(s)) begin
        rd_lock   = lock_v[s];
        rd_cfg    = cfg_a[s];
        rd_taken  = taken_v[s];
        rd_holder = holder_a[s];
      end
    end
  end

  // read mux
  always_comb begin
    reg_rdata_o = '0;
    if (is_ctrl)       reg_rdata_o = {31'b0, glock_q};
    else if (is_sec)   reg_rdata_o = sec_pad[int'(bank_k)*32 +: 32];
    else if (is_priv)  reg_rdata_o = priv_pad[int'(bank_k)*32 +: 32];
    else if (is_lock)  reg_rdata_o = lock_pad[int'(bank_k)*32 +: 32];
    else if (slot_in && !slot_sub)
      reg_rdata_o = {8'b0, rd_cfg.wl, 9'b0, rd_cfg.scid, 2'b0, rd_cfg.sem_en, rd_cfg.cfen};
    else if (slot_in && slot_sub)
      reg_rdata_o = {25'b0, rd_holder, 3'b0, rd_taken};
    else if (is_mctrl) reg_rdata_o = {25'b0, tdcid_q, 3'b0, mglock_q};
    else if (is_cap)   reg_rdata_o = {8'b0, 8'(NUM_MASTER), 16'(NUM_PERIPH)};
    else if (is_ver)   reg_rdata_o = {24'b0, 4'(VER_MAJ), 4'(VER_MIN)};
  end

  // global registers and error pulse
  logic err_d;
  assign err_d = (wr && !attr_ok && cfgspace) ||
                 (wr_ok && is_ctrl && glock_q) ||
                 (wr_ok && is_sec  && (glock_q || sec_diff)) ||
                 (wr_ok && is_priv && (glock_q || priv_diff)) ||
                 (wr_ok && is_lock && glock_q) ||
                 (wr_ok && slot_in && !slot_sub && (glock_q || rd_lock || !trust)) ||
                 (wr_ok && is_mctrl && mglock_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      glock_q  <= 1'b0;
      mglock_q <= 1'b0;
      tdcid_q  <= CID_W'(TD_CID_RST);
      err_q    <= 1'b0;
    end else begin
      err_q <= err_d;
      if (wr_ok && is_ctrl && !glock_q && reg_wdata_i[0]) glock_q <= 1'b1;
      if (wr_ok && is_mctrl && !mglock_q) begin
        tdcid_q  <= reg_wdata_i[6:4];
        mglock_q <= reg_wdata_i[0];
      end
    end
  end

  assign reg_err_o = err_q;

  // access check
  logic             c_in, c_sec, c_priv, c_taken;
  cid_cfg_t         c_cfg;
  logic [CID_W-1:0] c_holder;

  assign c_in = int'(chk_idx_i) < NUM_PERIPH;

  always_comb begin
    c_sec    = 1'b0;
    c_priv   = 1'b0;
    c_taken  = 1'b0;
    c_cfg    = '0;
    c_holder = '0;
    for (int s = 0; s < NUM_PERIPH; s++) begin
      if (chk_idx_i == IDX_W'(s)) begin
        c_sec    = sec_v[s];
        c_priv   = priv_v[s];
        c_taken  = taken_v[s];
        c_cfg    = cfg_a[s];
        c_holder = holder_a[s];
      end
    end
  end

  fw_decide u_decide (
    .in_range_i  (c_in),
    .slot_sec_i  (c_sec),
    .slot_priv_i (c_priv),
    .cfg_i       (c_cfg),
    .taken_i     (c_taken),
    .holder_i    (c_holder),
    .req_sec_i   (chk_sec_i),
    .req_priv_i  (chk_priv_i),
    .req_cid_i   (chk_cid_i),
    .grant_o     (chk_grant_o)
  );

  p_err_after_write_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_err_o |-> $past(reg_req_i && reg_we_i));

  p_mglock_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mglock_q |=> $stable(tdcid_q) && mglock_q);

  p_glock_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    glock_q |=> glock_q);

  p_oor_deny_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !c_in |-> !chk_grant_o);

  p_sec_deny_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_grant_o |-> (chk_sec_i || !c_sec));

  p_priv_deny_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_grant_o |-> (chk_priv_i || !c_priv));

  p_static_cid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_grant_o && c_cfg.cfen && !c_cfg.sem_en) |-> chk_cid_i == c_cfg.scid);

  p_sem_holder_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_grant_o && c_cfg.cfen && c_cfg.sem_en) |-> c_taken && c_holder == chk_cid_i);
endmodule

// File: tb/fw_filter_tb.sv
`timescale 1ns/1ps
module fw_filter_tb;
  localparam real CLK_P = 4.0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_req = 1'b0, reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [2:0]  reg_cid = '0;
  logic        reg_sec = 1'b0, reg_priv = 1'b0;
  logic [31:0] reg_rdata;
  logic        reg_err;
  logic [6:0]  chk_idx = '0;
  logic        chk_sec = 1'b0, chk_priv = 1'b0;
  logic [2:0]  chk_cid = '0;
  logic        chk_grant;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  fw_filter #(.NUM_PERIPH(40), .NUM_MASTER(16), .TD_CID_RST(1),
              .VER_MAJ(2), .VER_MIN(1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_req_i(reg_req), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_cid_i(reg_cid), .reg_sec_i(reg_sec),
    .reg_priv_i(reg_priv), .reg_rdata_o(reg_rdata), .reg_err_o(reg_err),
    .chk_idx_i(chk_idx), .chk_sec_i(chk_sec), .chk_priv_i(chk_priv),
    .chk_cid_i(chk_cid), .chk_grant_o(chk_grant)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // write; returns one time unit after the capturing edge
  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [2:0] cid,
                    input logic s = 1'b1, input logic p = 1'b1);
    @(negedge clk);
    reg_req = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    reg_cid = cid; reg_sec = s; reg_priv = p;
    @(posedge clk);
    #1;
    reg_req = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_req = 1'b1; reg_we = 1'b0; reg_addr = a;
    #1;
    d = reg_rdata;
    reg_req = 1'b0;
  endtask

  task automatic rdchk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic grant(input string req, input logic [6:0] idx, input logic s,
                       input logic p, input logic [2:0] cid, input logic exp);
    @(negedge clk);
    chk_idx = idx; chk_sec = s; chk_priv = p; chk_cid = cid;
    #1;
    check(req, {31'b0, chk_grant}, {31'b0, exp});
  endtask

  task automatic errchk(input string req, input logic exp);
    check(req, {31'b0, reg_err}, {31'b0, exp});
  endtask

  task automatic t_reset;
    rdchk("R1 ctrl", 12'h000, 32'h0);
    rdchk("R1 cfg slot0", 12'h100, 32'h0);
    rdchk("R1 sem slot0", 12'h104, 32'h0);
    rdchk("R1 sec bank", 12'h010, 32'h0);
    rdchk("R1 tdcid", 12'hC00, 32'h10);
    grant("R1 open grant", 7'd5, 1'b0, 1'b0, 3'd3, 1'b1);
    errchk("R1 err idle", 1'b0);
  endtask

  task automatic t_ident;
    rdchk("R11 cap", 12'hFEC, 32'h0010_0028);
    rdchk("R11 ver", 12'hFF4, 32'h0000_0021);
    wr(12'hFEC, 32'hFFFF_FFFF, 3'd1);
    rdchk("R11 cap ro", 12'hFEC, 32'h0010_0028);
    wr(12'hFF4, 32'h0, 3'd1);
    rdchk("R11 ver ro", 12'hFF4, 32'h0000_0021);
  endtask

  task automatic t_secpriv;
    wr(12'h010, 32'h20, 3'd1);
    errchk("R13 legal write no err", 1'b0);
    rdchk("R2 sec word0", 12'h010, 32'h20);
    grant("R2 nonsec deny", 7'd5, 1'b0, 1'b1, 3'd0, 1'b0);
    grant("R2 sec grant", 7'd5, 1'b1, 1'b0, 3'd0, 1'b1);
    grant("R2 neighbour open", 7'd4, 1'b0, 1'b0, 3'd0, 1'b1);
    wr(12'h014, 32'h20, 3'd1);
    grant("R2 slot37 deny", 7'd37, 1'b0, 1'b1, 3'd0, 1'b0);
    grant("R2 slot5 via word1 unchanged", 7'd5, 1'b1, 1'b1, 3'd0, 1'b1);
    wr(12'h030, 32'h20, 3'd1);
    rdchk("R3 priv word0", 12'h030, 32'h20);
    grant("R3 unpriv deny", 7'd5, 1'b1, 1'b0, 3'd0, 1'b0);
    grant("R3 priv grant", 7'd5, 1'b1, 1'b1, 3'd0, 1'b1);
    grant("R2 sec before priv", 7'd5, 1'b0, 1'b1, 3'd0, 1'b0);
  endtask

  task automatic t_static;
    wr(12'h130, 32'h31, 3'd1);
    rdchk("R5 cfg readback", 12'h130, 32'h31);
    grant("R5 owner grant", 7'd6, 1'b0, 1'b0, 3'd3, 1'b1);
    grant("R5 other deny", 7'd6, 1'b0, 1'b0, 3'd2, 1'b0);
    wr(12'h138, 32'hFFF0_FF3C, 3'd1);
    rdchk("R4 cfg mask", 12'h138, 32'h00F0_0030);
    grant("R4 filter off grant", 7'd7, 1'b0, 1'b0, 3'd2, 1'b1);
  endtask

  task automatic t_sem;
    wr(12'h140, 32'h0014_0003, 3'd1);
    grant("R6 free deny", 7'd8, 1'b0, 1'b0, 3'd2, 1'b0);
    wr(12'h144, 32'h1, 3'd3, 1'b0, 1'b0);
    rdchk("R7 non-whitelisted take", 12'h144, 32'h0);
    wr(12'h144, 32'h1, 3'd2, 1'b0, 1'b0);
    errchk("R14 sem write unrestricted", 1'b0);
    rdchk("R7 take by 2", 12'h144, 32'h21);
    grant("R6 holder grant", 7'd8, 1'b0, 1'b0, 3'd2, 1'b1);
    grant("R6 whitelisted non-holder deny", 7'd8, 1'b0, 1'b0, 3'd4, 1'b0);
    wr(12'h144, 32'h1, 3'd4);
    rdchk("R7 take while held", 12'h144, 32'h21);
    wr(12'h144, 32'h0, 3'd4);
    rdchk("R7 release by non-holder", 12'h144, 32'h21);
    wr(12'h144, 32'h0, 3'd2);
    rdchk("R7 release by holder", 12'h144, 32'h0);
    wr(12'h144, 32'h1, 3'd4);
    rdchk("R7 take by 4", 12'h144, 32'h41);
    grant("R6 new holder grant", 7'd8, 1'b0, 1'b0, 3'd4, 1'b1);
    wr(12'h14C, 32'h1, 3'd1);
    rdchk("R7 no sem mode no take", 12'h14C, 32'h0);
  endtask

  task automatic t_lock;
    wr(12'h150, 32'h11, 3'd1);
    wr(12'h050, 32'h400, 3'd1);
    errchk("R8 lock set no err", 1'b0);
    rdchk("R8 lock bank", 12'h050, 32'h400);
    wr(12'h150, 32'h21, 3'd1);
    errchk("R8 locked cfg err", 1'b1);
    @(posedge clk); #1;
    errchk("R13 err one cycle", 1'b0);
    rdchk("R8 cfg kept", 12'h150, 32'h11);
    grant("R8 old owner grant", 7'd10, 1'b0, 1'b0, 3'd1, 1'b1);
    wr(12'h010, 32'h420, 3'd1);
    errchk("R8 locked bit change err", 1'b1);
    rdchk("R8 locked sec bit kept", 12'h010, 32'h20);
    wr(12'h010, 32'h0, 3'd1);
    errchk("R8 unlocked change no err", 1'b0);
    rdchk("R8 unlocked bit updated", 12'h010, 32'h0);
    wr(12'h010, 32'h20, 3'd1);
    wr(12'h050, 32'h0, 3'd1);
    rdchk("R8 lock sticky", 12'h050, 32'h400);
  endtask

  task automatic t_oor;
    rdchk("R12 oor cfg read", 12'h240, 32'h0);
    wr(12'h240, 32'h1, 3'd1);
    errchk("R12 oor write no err", 1'b0);
    rdchk("R12 oor cfg still zero", 12'h240, 32'h0);
    wr(12'h014, 32'h120, 3'd1);
    rdchk("R12 bank bit40 dropped", 12'h014, 32'h20);
    grant("R12 idx40 deny", 7'd40, 1'b1, 1'b1, 3'd0, 1'b0);
    grant("R12 idx127 deny", 7'd127, 1'b1, 1'b1, 3'd1, 1'b0);
    grant("R12 idx39 grant", 7'd39, 1'b0, 1'b0, 3'd0, 1'b1);
  endtask

  task automatic t_trust;
    wr(12'h148, 32'h21, 3'd2);
    errchk("R10 untrusted cfg err", 1'b1);
    rdchk("R10 untrusted cfg ignored", 12'h148, 32'h0);
    wr(12'h148, 32'h21, 3'd1, 1'b0, 1'b1);
    errchk("R14 nonsec writer err", 1'b1);
    wr(12'h148, 32'h21, 3'd1, 1'b1, 1'b0);
    errchk("R14 unpriv writer err", 1'b1);
    rdchk("R14 cfg ignored", 12'h148, 32'h0);
    wr(12'hC00, 32'h20, 3'd1);
    errchk("R10 mctrl write ok", 1'b0);
    rdchk("R10 tdcid moved", 12'hC00, 32'h20);
    wr(12'h148, 32'h21, 3'd2);
    errchk("R10 trusted cfg ok", 1'b0);
    rdchk("R10 trusted cfg stored", 12'h148, 32'h21);
    wr(12'hC00, 32'h21, 3'd1);
    wr(12'hC00, 32'h10, 3'd1);
    errchk("R10 mlock err", 1'b1);
    rdchk("R10 mctrl frozen", 12'hC00, 32'h21);
  endtask

  task automatic t_glock;
    logic [31:0] v;
    wr(12'h000, 32'h1, 3'd1);
    errchk("R9 glock set ok", 1'b0);
    rdchk("R9 glock read", 12'h000, 32'h1);
    rd(12'h010, v);
    wr(12'h010, 32'hFFFF_FFFF, 3'd1);
    errchk("R9 bank err", 1'b1);
    rdchk("R9 bank frozen", 12'h010, v);
    wr(12'h148, 32'h0, 3'd2);
    errchk("R9 cfg err", 1'b1);
    rdchk("R9 cfg frozen", 12'h148, 32'h21);
    wr(12'h050, 32'h1, 3'd1);
    errchk("R9 lock bank err", 1'b1);
    rdchk("R9 lock bank frozen", 12'h050, 32'h400);
    wr(12'h144, 32'h0, 3'd4);
    rdchk("R9 sem release works", 12'h144, 32'h0);
    wr(12'h144, 32'h1, 3'd2);
    rdchk("R9 sem take works", 12'h144, 32'h21);
    wr(12'h000, 32'h0, 3'd1);
    errchk("R9 ctrl write err", 1'b1);
    rdchk("R9 glock sticky", 12'h000, 32'h1);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_ident();
    t_secpriv();
    t_static();
    t_sem();
    t_lock();
    t_oor();
    t_trust();
    t_glock();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule